// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges the reset requests of a processor subsystem into a single system reset output and records in a 16-bit status word which sources caused it. There are five sources. The first is an active-low board pin, which is synchronized and filtered against short glitches. The second is a one-cycle software reset strobe. The third is a watchdog time-out. The fourth is a hard-trap conflict detector fed by trap raise and retire events. The fifth is an illegal-condition request.

The watchdog behaves differently depending on the power state. While the core runs, a time-out drives the reset output asynchronously. While the core sleeps or idles, a time-out only produces a wake-up pulse. Status flags survive the reset they describe, so firmware can read them after restart. Firmware clears them with a masked write strobe.

Top module: `reset_hub`

## Requirements
- R1: While `porN` is low, `rstStatus` is 0 and `sysRst` and `wakePulse` are 0. Every other input is idle.
- R2: The pin `extRstN` passes through two synchronizer flops before a low-time counter. A low lasting L clock cycles, with L at least `MIN_LOW` (default 4), raises `sysRst` for exactly L-`MIN_LOW`+1 cycles and sets status bit 7. A shorter low has no effect on `sysRst` or the status.
- R3: A one-cycle `swRstReq` raises `sysRst` for exactly one cycle, starting on the next cycle, and sets status bit 6.
- R4: A one-cycle `wdtTimeout` with `lowPower` low drives `sysRst` high in the same cycle, before any clock edge. The reset is held for one more registered cycle, for two cycles in all, and status bit 4 is set.
- R5: A `wdtTimeout` with `lowPower` high gives a one-cycle `wakePulse` on the next cycle. It does not raise `sysRst` and leaves status bit 4 clear.
- R6: Hard traps have levels 13 to 15. A `trapRaise` at a hard level strictly below the hard level currently being serviced raises `sysRst` for one cycle and sets status bit 15.
- R7: A hard trap at an equal or higher level nests without a reset. Levels below 13 are ignored by the detector. A `trapRetire` ends service, so a later lower hard trap causes no conflict.
- R8: A one-cycle `illegalReq` raises `sysRst` for one cycle and sets status bit 14.
- R9: Sources active in the same cycle set every matching flag and produce a single reset window.
- R10: Status flags are sticky. A `statusClrWr` clears exactly the bits set in `statusClrMask`, and a flag being set in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| extRstN | input | 1 | Board reset pin, active low, asynchronous |
| swRstReq | input | 1 | Software reset instruction strobe |
| wdtTimeout | input | 1 | Watchdog time-out strobe |
| lowPower | input | 1 | Core is in sleep or idle mode |
| trapRaise | input | 1 | A trap is taken this cycle |
| trapLevel | input | 4 | Priority level of the trap being taken |
| trapRetire | input | 1 | Service of the current trap has ended |
| illegalReq | input | 1 | Illegal-condition reset request |
| statusClrWr | input | 1 | Masked clear strobe for the status word |
| statusClrMask | input | 16 | Bits to clear when `statusClrWr` is high |
| sysRst | output | 1 | System reset output |
| wakePulse | output | 1 | One-cycle wake-up from a sleeping time-out |
| rstStatus | output | 16 | Sticky reset cause flags |

## Verification
A table of strobe combinations drives the software, watchdog and illegal-condition sources. It covers each source alone and in pairs, and runs the watchdog both with and without low power. The resulting reset widths and flags separate the registered one-cycle reset from the two-cycle asynchronous watchdog reset. They also separate a wake-up from a reset, and show a merged reset window apart from separate ones. Pin lows of 3, 4 and 10 cycles locate the filter threshold and the hold-while-low length. Trap pairs in descending, ascending, equal, soft-level and retired order show that only a true priority inversion resets the core.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int STAT_W   = 16;
  localparam int TRAP_BIT = 15;
  localparam int ILL_BIT  = 14;
  localparam int EXT_BIT  = 7;
  localparam int SW_BIT   = 6;
  localparam int WDT_BIT  = 4;

  // strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic setTrap;
    logic setIll;
    logic setExt;
    logic setSw;
    logic setWdt;
    logic wake;
    logic rstReq;
  } hubStrobeT;
endpackage

// File: rtl/reset_hub_ctrl.sv
module reset_hub_ctrl
  import reset_hub_pkg::*;
#(
  parameter int MIN_LOW     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 4,
  parameter int HARD_LO     = 13
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic             swRstReq,
  input  logic             wdtTimeout,
  input  logic             lowPower,
  input  logic             trapRaise,
  input  logic [LVL_W-1:0] trapLevel,
  input  logic             trapRetire,
  input  logic             illegalReq,
  output hubStrobeT        strobe,
  output logic             wdtAsync
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_LOW);
  localparam logic [LVL_W-1:0] HARD_LVL = LVL_W'(HARD_LO);
  localparam logic [LVL_W-1:0] NO_TRAP  = '0;

  // pin synchronizer, idle level high
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge porN)
        if (!porN) syncQ <= '1;
        else       syncQ <= extRstN;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge porN)
        if (!porN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extRstN};
    end
  endgenerate

  logic pinLow;
  assign pinLow = ~syncQ[SYNC_STAGES-1];

  // low-time counter, saturates at the threshold
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge porN)
    if (!porN)             lowCnt <= '0;
    else if (!pinLow)      lowCnt <= '0;
    else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;

  logic extQual;
  assign extQual = (lowCnt == CNT_MAX);

  // hard trap service tracking
  logic [LVL_W-1:0] curLevel;
  logic isHard, trapConflict, trapNest;
  assign isHard       = trapRaise && (trapLevel >= HARD_LVL);
  assign trapConflict = isHard && (curLevel != NO_TRAP) && (trapLevel < curLevel);
  assign trapNest     = isHard && (trapLevel > curLevel);

  logic wdtRun, wdtSleep, anyReq;
  assign wdtRun   = wdtTimeout & ~lowPower;
  assign wdtSleep = wdtTimeout &  lowPower;
  assign anyReq   = extQual | swRstReq | wdtRun | trapConflict | illegalReq;

  always_ff @(posedge clk or negedge porN)
    if (!porN)           curLevel <= NO_TRAP;
    else if (anyReq)     curLevel <= NO_TRAP;
    else if (trapRetire) curLevel <= NO_TRAP;
    else if (trapNest)   curLevel <= trapLevel;

  always_comb begin
    strobe.setTrap = trapConflict;
    strobe.setIll  = illegalReq;
    strobe.setExt  = extQual;
    strobe.setSw   = swRstReq;
    strobe.setWdt  = wdtRun;
    strobe.wake    = wdtSleep;
    strobe.rstReq  = anyReq;
  end

  assign wdtAsync = wdtRun;
endmodule

// File: rtl/reset_hub_dp.sv
module reset_hub_dp
  import reset_hub_pkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  hubStrobeT         strobe,
  input  logic              wdtAsync,
  input  logic              statusClrWr,
  input  logic [STAT_W-1:0] statusClrMask,
  output logic              sysRst,
  output logic              wakePulse,
  output logic [STAT_W-1:0] rstStatus
);
  logic [STAT_W-1:0] setVec, clrVec, statusQ;
  logic rstQ, wakeQ;

  always_comb begin
    setVec           = '0;
    setVec[TRAP_BIT] = strobe.setTrap;
    setVec[ILL_BIT]  = strobe.setIll;
    setVec[EXT_BIT]  = strobe.setExt;
    setVec[SW_BIT]   = strobe.setSw;
    setVec[WDT_BIT]  = strobe.setWdt;
    clrVec           = statusClrWr ? statusClrMask : '0;
  end

  always_ff @(posedge clk or negedge porN)
    if (!porN) begin
      statusQ <= '0;
      rstQ    <= 1'b0;
      wakeQ   <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
      rstQ    <= strobe.rstReq;
      wakeQ   <= strobe.wake;
    end

  assign sysRst    = rstQ | wdtAsync;
  assign wakePulse = wakeQ;
  assign rstStatus = statusQ;
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int MIN_LOW = 4,
  parameter int HARD_LO = 13
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        extRstN,
  input  logic        swRstReq,
  input  logic        wdtTimeout,
  input  logic        lowPower,
  input  logic        trapRaise,
  input  logic [3:0]  trapLevel,
  input  logic        trapRetire,
  input  logic        illegalReq,
  input  logic        statusClrWr,
  input  logic [15:0] statusClrMask,
  output logic        sysRst,
  output logic        wakePulse,
  output logic [15:0] rstStatus
);
  hubStrobeT strobe;
  logic wdtAsync;

  reset_hub_ctrl #(
    .MIN_LOW(MIN_LOW), .SYNC_STAGES(2), .LVL_W(4), .HARD_LO(HARD_LO)
  ) u_ctrl (
    .clk(clk), .porN(porN), .extRstN(extRstN), .swRstReq(swRstReq),
    .wdtTimeout(wdtTimeout), .lowPower(lowPower), .trapRaise(trapRaise),
    .trapLevel(trapLevel), .trapRetire(trapRetire), .illegalReq(illegalReq),
    .strobe(strobe), .wdtAsync(wdtAsync)
  );

  reset_hub_dp u_dp (
    .clk(clk), .porN(porN), .strobe(strobe), .wdtAsync(wdtAsync),
    .statusClrWr(statusClrWr), .statusClrMask(statusClrMask),
    .sysRst(sysRst), .wakePulse(wakePulse), .rstStatus(rstStatus)
  );
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk (
  input logic        clk,
  input logic        porN,
  input logic        swRstReq,
  input logic        wdtTimeout,
  input logic        lowPower,
  input logic        illegalReq,
  input logic        statusClrWr,
  input logic        sysRst,
  input logic        wakePulse,
  input logic [15:0] rstStatus
);
  // R3
  sw_reset_chk: assert property (@(posedge clk) disable iff (!porN)
    swRstReq |=> (sysRst && rstStatus[6]));

  // R4
  wdt_async_chk: assert property (@(posedge clk) disable iff (!porN)
    (wdtTimeout && !lowPower) |-> sysRst);

  // R5
  wdt_wake_chk: assert property (@(posedge clk) disable iff (!porN)
    (wdtTimeout && lowPower) |=> wakePulse);

  // R8
  illegal_chk: assert property (@(posedge clk) disable iff (!porN)
    illegalReq |=> (sysRst && rstStatus[14]));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    !statusClrWr |=> ((rstStatus & $past(rstStatus)) == $past(rstStatus)));
endmodule

bind reset_hub reset_hub_chk u_chk (.*);

// File: tb/reset_hub_bench.sv
module reset_hub_bench;
  logic clk = 1'b0;
  logic porN = 1'b0;
  logic extRstN = 1'b1, swRstReq = 1'b0, wdtTimeout = 1'b0, lowPower = 1'b0;
  logic trapRaise = 1'b0, trapRetire = 1'b0, illegalReq = 1'b0, statusClrWr = 1'b0;
  logic [3:0]  trapLevel = 4'd0;
  logic [15:0] statusClrMask = 16'h0;
  logic sysRst, wakePulse;
  logic [15:0] rstStatus;

  int errors = 0, checks = 0;
  int rstSeen = 0, wakeSeen = 0;

  reset_hub u_reset_hub (.*);

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (sysRst) rstSeen++;
    if (wakePulse) wakeSeen++;
  end

  typedef struct packed {
    logic sw; logic wdt; logic lp; logic ill;
    logic [15:0] st; logic [3:0] rst; logic wake;
  } vecT;

  localparam vecT VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'h0040, 4'd1, 1'b0},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0010, 4'd2, 1'b0},  // R4
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd0, 1'b1},  // R5
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'h4000, 4'd1, 1'b0},  // R8
    '{1'b1, 1'b0, 1'b0, 1'b1, 16'h4040, 4'd1, 1'b0},  // R9
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h0050, 4'd2, 1'b0},  // R9
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'h0040, 4'd1, 1'b1},  // R5 R9
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd0, 1'b0}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clearAll();
    statusClrWr = 1'b1; statusClrMask = 16'hFFFF;
    tick();
    statusClrWr = 1'b0; statusClrMask = 16'h0;
    tick();
  endtask

  task automatic extPulse(int len, int expRst, int expFlag);
    clearAll();
    rstSeen = 0;
    extRstN = 1'b0;
    repeat (len) tick();
    extRstN = 1'b1;
    repeat (6) tick();
    check("R2 ext reset width", rstSeen, expRst);
    check("R2 ext flag bit7", int'(rstStatus[7]), expFlag);
  endtask

  task automatic trapPair(int l1, int l2, bit retire, int expHit, string tag);
    clearAll();
    rstSeen = 0;
    trapRaise = 1'b1; trapLevel = 4'(l1);
    tick();
    trapRaise = 1'b0;
    if (retire) begin
      trapRetire = 1'b1; tick(); trapRetire = 1'b0;
    end
    trapRaise = 1'b1; trapLevel = 4'(l2);
    tick();
    trapRaise = 1'b0; trapLevel = 4'd0;
    repeat (3) tick();
    check(tag, int'(rstStatus[15]), expHit);
    check({tag, " reset count"}, rstSeen, expHit);
    trapRetire = 1'b1; tick(); trapRetire = 1'b0;
    tick();
  endtask

  initial begin
    #(8 * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 status in reset", int'(rstStatus), 0);
    check("R1 sysRst in reset", int'(sysRst), 0);
    check("R1 wake in reset", int'(wakePulse), 0);
    porN = 1'b1;
    tick(); tick();

    // vector table: software, watchdog, illegal
    foreach (VEC[i]) begin
      clearAll();
      rstSeen = 0; wakeSeen = 0;
      swRstReq = VEC[i].sw; wdtTimeout = VEC[i].wdt;
      lowPower = VEC[i].lp; illegalReq = VEC[i].ill;
      tick();
      swRstReq = 1'b0; wdtTimeout = 1'b0; lowPower = 1'b0; illegalReq = 1'b0;
      repeat (4) tick();
      check($sformatf("R9 vec%0d status (R3 R4 R5 R8)", i), int'(rstStatus), int'(VEC[i].st));
      check($sformatf("R9 vec%0d reset cycles", i), rstSeen, int'(VEC[i].rst));
      check($sformatf("R5 vec%0d wake cycles", i), wakeSeen, int'(VEC[i].wake));
    end

    // R4 asynchronous assertion before any edge
    clearAll();
    wdtTimeout = 1'b1;
    #1;
    check("R4 same-cycle reset", int'(sysRst), 1);
    tick();
    wdtTimeout = 1'b0;
    repeat (3) tick();

    // R2 pin filter
    extPulse(3, 0, 0);
    extPulse(4, 1, 1);
    extPulse(10, 7, 1);

    // R6 / R7 trap conflicts
    trapPair(14, 13, 1'b0, 1, "R6 14 then 13");
    trapPair(15, 13, 1'b0, 1, "R6 15 then 13");
    trapPair(13, 14, 1'b0, 0, "R7 13 then 14");
    trapPair(15, 15, 1'b0, 0, "R7 15 then 15");
    trapPair(15, 12, 1'b0, 0, "R7 soft level");
    trapPair(14, 13, 1'b1, 0, "R7 retired");

    // R10 masked clear and set-over-clear
    clearAll();
    swRstReq = 1'b1; illegalReq = 1'b1;
    tick();
    swRstReq = 1'b0; illegalReq = 1'b0;
    repeat (3) tick();
    statusClrWr = 1'b1; statusClrMask = 16'h0040;
    tick();
    statusClrWr = 1'b0; statusClrMask = 16'h0;
    tick();
    check("R10 masked clear", int'(rstStatus), 16'h4000);
    swRstReq = 1'b1; statusClrWr = 1'b1; statusClrMask = 16'h0040;
    tick();
    swRstReq = 1'b0; statusClrWr = 1'b0; statusClrMask = 16'h0;
    repeat (3) tick();
    check("R10 set wins over clear", int'(rstStatus), 16'h4040);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule